// File: doc/BRIEF.md
# User Interrupt Send Engine

This block carries out one request to deliver a user-level interrupt to another processor. A requester hands it a 64-bit index. The engine checks that the feature is switched on and that the index falls inside the target table. It then fetches the 16-byte table slot that the index selects and screens that slot for validity and for bits that must be clear. If the slot passes, the engine follows the slot's pointer to a 16-byte posted-interrupt descriptor. It reads and rewrites that descriptor under a held memory lock, setting the request bit for the slot's vector.

If the descriptor shows neither a pending notification nor suppression, the rewrite also marks a notification as pending. The engine then raises an ordinary interprocessor interrupt request. That request carries the descriptor's notification vector and a destination chosen according to the APIC addressing mode. Every request ends with a one-cycle completion pulse and an outcome code: success, general-protection fault or undefined-opcode fault.

The memory side moves one 128-bit word per transfer, with a valid/ready request and a response strobe. A write is complete when its response strobe arrives.

Top module: `uipi_send_engine`

## Requirements
- R1: When bit 0 of `cfg_table_base` is 0, an accepted request completes on the next cycle with `fault` = 2'b10 (undefined opcode) and issues no memory request.
- R2: When the index is greater than `cfg_table_size` (compared as unsigned 64-bit values), the request completes with `fault` = 2'b01 (general protection) and makes no memory access. An index equal to the size proceeds to the table read.
- R3: The first memory access is an unlocked read at (`cfg_table_base` with bits 3:0 cleared) + index*16.
- R4: The table slot faults with 2'b01, and no further access is made, if any of these hold: bit 0 (valid) is 0; bits 7:1 are nonzero; bits 15:14 are nonzero (vector bits 13:8 give 0..63); bits 63:16 are nonzero; or bits 69:64 are nonzero. Bits 127:64 hold the descriptor address.
- R5: The descriptor is read at the slot's address with `mem_lock` high. The lock stays high through the completion of the write-back, and every write request carries the lock.
- R6: A descriptor with any of bits 15:2 or 31:24 set faults with 2'b01. In that case the lock drops, and no write and no interrupt request follow.
- R7: The write-back data equals the descriptor read, with bit 64+vector set. Bit 0 (pending) is also set when bits 0 and 1 (suppress) were both 0 on the read.
- R8: An interrupt request is raised with `ipi_vector` = descriptor bits 23:16 only when bits 0 and 1 were both 0 on the read. It is raised after the write completes and with the lock released. Completion then comes one cycle after the request is accepted. With no notification, completion follows the write response directly.
- R9: With `cfg_x2apic` = 1, `ipi_dest` equals descriptor bits 63:32. Otherwise it equals descriptor bits 47:40, zero-extended. `ipi_x2apic` reports the mode that was used.
- R10: `req_ready` is high only while the engine is idle and `done` is low. `done` is a one-cycle pulse, and `fault` is 2'b00 on success. After reset, `done`, `mem_req_valid`, `mem_lock` and `ipi_valid` are 0.
- R11: While `ipi_valid` is high and `ipi_ready` is low, the interrupt request and its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Engine can accept a request |
| req_index | input | 64 | Target table index |
| cfg_table_base | input | 64 | Table base address; bit 0 is the feature enable |
| cfg_table_size | input | 32 | Highest legal index |
| cfg_x2apic | input | 1 | 1 selects 32-bit destination IDs |
| mem_req_valid | output | 1 | Memory transfer request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 64 | Byte address of the 16-byte word |
| mem_req_wdata | output | 128 | Write data |
| mem_lock | output | 1 | Holds the memory locked across the descriptor update |
| mem_rsp_valid | input | 1 | Read data valid or write completed |
| mem_rsp_data | input | 128 | Read data |
| ipi_valid | output | 1 | Interrupt request present |
| ipi_ready | input | 1 | Interrupt request accepted |
| ipi_vector | output | 8 | Notification vector |
| ipi_dest | output | 32 | Destination processor ID |
| ipi_x2apic | output | 1 | Mode of the destination ID |
| done | output | 1 | Request finished (one cycle) |
| fault | output | 2 | Outcome: 00 none, 01 general protection, 10 undefined opcode |

## Verification
The write-back and the notification decision are made together on the same descriptor read. The value of the pending flag in the written word must therefore agree with whether an interrupt request later appears. The bench provokes this with descriptors that have neither flag set, only the pending flag set, or only the suppress flag set. For each case it compares the captured write data with the presence of an interrupt request. The bench also holds `ipi_ready` low for several cycles and checks that completion arrives exactly one cycle after acceptance, and never while the lock is still held.

// File: rtl/uipi_pkg.sv
package uipi_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_UD   = 2'b10
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ENT_REQ,
    S_ENT_WAIT,
    S_DSC_REQ,
    S_DSC_WAIT,
    S_WB_REQ,
    S_WB_WAIT,
    S_NOTIFY
  } eng_state_e;

  // table slot field positions
  localparam int SLOT_VALID_BIT = 0;
  localparam int SLOT_VEC_LO    = 8;
  localparam int SLOT_VEC_HI    = 15;
  localparam int SLOT_PTR_LO    = 64;
  localparam int PTR_ALIGN_BITS = 6;

  // descriptor field positions
  localparam int DSC_PEND_BIT = 0;
  localparam int DSC_SUPP_BIT = 1;
  localparam int DSC_NV_LO    = 16;
  localparam int DSC_DST_LO   = 32;
  localparam int DSC_PIR_LO   = 64;
  localparam int XAPIC_ID_LO  = 8;

  localparam int SLOT_BYTES_LOG2 = 4;

endpackage

// File: rtl/uipi_slot_check.sv
module uipi_slot_check
  import uipi_pkg::*;
#(
  parameter int LINE_W = 128,
  parameter int ADDR_W = 64,
  parameter int VEC_W  = 6
) (
  input  logic [LINE_W-1:0] slot,
  output logic              slot_bad,
  output logic [VEC_W-1:0]  slot_vec,
  output logic [ADDR_W-1:0] slot_ptr
);
  localparam int VEC_FIELD_W = SLOT_VEC_HI - SLOT_VEC_LO + 1;
  localparam int VEC_PAD_W   = VEC_FIELD_W - VEC_W;

  logic [VEC_FIELD_W-1:0] vec_field;
  logic                   flag_rsvd, vec_rsvd, mid_rsvd, align_rsvd;

  assign vec_field  = slot[SLOT_VEC_HI:SLOT_VEC_LO];
  assign flag_rsvd  = |slot[SLOT_VEC_LO-1:SLOT_VALID_BIT+1];
  assign vec_rsvd   = |vec_field[VEC_FIELD_W-1 -: VEC_PAD_W];
  assign mid_rsvd   = |slot[SLOT_PTR_LO-1:SLOT_VEC_HI+1];
  assign align_rsvd = |slot[SLOT_PTR_LO +: PTR_ALIGN_BITS];

  assign slot_bad = !slot[SLOT_VALID_BIT] | flag_rsvd | vec_rsvd | mid_rsvd | align_rsvd;
  assign slot_vec = vec_field[VEC_W-1:0];
  assign slot_ptr = slot[SLOT_PTR_LO +: ADDR_W];
endmodule

// File: rtl/uipi_desc_update.sv
module uipi_desc_update
  import uipi_pkg::*;
#(
  parameter int LINE_W   = 128,
  parameter int NUM_UVEC = 64,
  parameter int VEC_W    = 6,
  parameter int NV_W     = 8,
  parameter int APIC_W   = 32
) (
  input  logic [LINE_W-1:0] dsc_in,
  input  logic [VEC_W-1:0]  uvec,
  output logic              dsc_bad,
  output logic              dsc_notify,
  output logic [LINE_W-1:0] dsc_out,
  output logic [NV_W-1:0]   dsc_nv,
  output logic [APIC_W-1:0] dsc_dst
);
  logic [NUM_UVEC-1:0] pir_old, pir_new;
  logic                low_rsvd, high_rsvd, quiet;

  assign pir_old   = dsc_in[DSC_PIR_LO +: NUM_UVEC];
  assign low_rsvd  = |dsc_in[DSC_NV_LO-1:DSC_SUPP_BIT+1];
  assign high_rsvd = |dsc_in[DSC_DST_LO-1:DSC_NV_LO+NV_W];
  assign dsc_bad   = low_rsvd | high_rsvd;
  assign quiet     = !dsc_in[DSC_PEND_BIT] && !dsc_in[DSC_SUPP_BIT];
  assign dsc_notify = quiet;

  for (genvar v = 0; v < NUM_UVEC; v++) begin : g_post
    assign pir_new[v] = pir_old[v] | (uvec == VEC_W'(v));
  end

  always_comb begin
    dsc_out = dsc_in;
    dsc_out[DSC_PIR_LO +: NUM_UVEC] = pir_new;
    if (quiet) dsc_out[DSC_PEND_BIT] = 1'b1;
  end

  assign dsc_nv  = dsc_in[DSC_NV_LO +: NV_W];
  assign dsc_dst = dsc_in[DSC_DST_LO +: APIC_W];
endmodule

// File: rtl/uipi_dest_route.sv
module uipi_dest_route
  import uipi_pkg::*;
#(
  parameter int APIC_W  = 32,
  parameter int XAPIC_W = 8
) (
  input  logic [APIC_W-1:0] dst_field,
  input  logic              wide_mode,
  output logic [APIC_W-1:0] dst_id
);
  logic [XAPIC_W-1:0] short_id;

  assign short_id = dst_field[XAPIC_ID_LO +: XAPIC_W];
  assign dst_id   = wide_mode ? dst_field : {{(APIC_W-XAPIC_W){1'b0}}, short_id};
endmodule

// File: rtl/uipi_send_engine.sv
module uipi_send_engine
  import uipi_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = 64,
  parameter int SIZE_W   = 32,
  parameter int LINE_W   = 128,
  parameter int APIC_W   = 32,
  parameter int NV_W     = 8,
  parameter int NUM_UVEC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [ADDR_W-1:0] cfg_table_base,
  input  logic [SIZE_W-1:0] cfg_table_size,
  input  logic              cfg_x2apic,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  output logic              mem_lock,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data,
  output logic              ipi_valid,
  input  logic              ipi_ready,
  output logic [NV_W-1:0]   ipi_vector,
  output logic [APIC_W-1:0] ipi_dest,
  output logic              ipi_x2apic,
  output logic              done,
  output logic [1:0]        fault
);
  localparam int VEC_W = $clog2(NUM_UVEC);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'((1 << SLOT_BYTES_LOG2) - 1);

  eng_state_e st;
  logic [VEC_W-1:0]  uv_q;
  logic              notify_q;

  logic              en_bit, over_size;
  logic [ADDR_W-1:0] slot_addr;

  logic              slot_bad;
  logic [VEC_W-1:0]  slot_vec;
  logic [ADDR_W-1:0] slot_ptr;

  logic              dsc_bad, dsc_notify;
  logic [LINE_W-1:0] dsc_new;
  logic [NV_W-1:0]   dsc_nv;
  logic [APIC_W-1:0] dsc_dst, route_id;

  assign en_bit    = cfg_table_base[0];
  assign over_size = req_index > IDX_W'(cfg_table_size);
  assign slot_addr = (cfg_table_base & BASE_MASK)
                   + (ADDR_W'(req_index) << SLOT_BYTES_LOG2);
  assign req_ready = (st == S_IDLE) && !done;

  uipi_slot_check #(
    .LINE_W (LINE_W),
    .ADDR_W (ADDR_W),
    .VEC_W  (VEC_W)
  ) u_slot (
    .slot     (mem_rsp_data),
    .slot_bad (slot_bad),
    .slot_vec (slot_vec),
    .slot_ptr (slot_ptr)
  );

  uipi_desc_update #(
    .LINE_W   (LINE_W),
    .NUM_UVEC (NUM_UVEC),
    .VEC_W    (VEC_W),
    .NV_W     (NV_W),
    .APIC_W   (APIC_W)
  ) u_desc (
    .dsc_in     (mem_rsp_data),
    .uvec       (uv_q),
    .dsc_bad    (dsc_bad),
    .dsc_notify (dsc_notify),
    .dsc_out    (dsc_new),
    .dsc_nv     (dsc_nv),
    .dsc_dst    (dsc_dst)
  );

  uipi_dest_route #(
    .APIC_W  (APIC_W),
    .XAPIC_W (8)
  ) u_route (
    .dst_field (dsc_dst),
    .wide_mode (cfg_x2apic),
    .dst_id    (route_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      uv_q          <= '0;
      notify_q      <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      mem_lock      <= 1'b0;
      ipi_valid     <= 1'b0;
      ipi_vector    <= '0;
      ipi_dest      <= '0;
      ipi_x2apic    <= 1'b0;
      done          <= 1'b0;
      fault         <= FLT_NONE;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            if (!en_bit) begin
              done  <= 1'b1;
              fault <= FLT_UD;
            end else if (over_size) begin
              done  <= 1'b1;
              fault <= FLT_GP;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_write <= 1'b0;
              mem_req_addr  <= slot_addr;
              st            <= S_ENT_REQ;
            end
          end
        end
        S_ENT_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st            <= S_ENT_WAIT;
          end
        end
        S_ENT_WAIT: begin
          if (mem_rsp_valid) begin
            if (slot_bad) begin
              done  <= 1'b1;
              fault <= FLT_GP;
              st    <= S_IDLE;
            end else begin
              uv_q          <= slot_vec;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= slot_ptr;
              mem_lock      <= 1'b1;
              st            <= S_DSC_REQ;
            end
          end
        end
        S_DSC_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st            <= S_DSC_WAIT;
          end
        end
        S_DSC_WAIT: begin
          if (mem_rsp_valid) begin
            if (dsc_bad) begin
              mem_lock <= 1'b0;
              done     <= 1'b1;
              fault    <= FLT_GP;
              st       <= S_IDLE;
            end else begin
              mem_req_wdata <= dsc_new;
              mem_req_write <= 1'b1;
              mem_req_valid <= 1'b1;
              notify_q      <= dsc_notify;
              ipi_vector    <= dsc_nv;
              ipi_dest      <= route_id;
              ipi_x2apic    <= cfg_x2apic;
              st            <= S_WB_REQ;
            end
          end
        end
        S_WB_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st            <= S_WB_WAIT;
          end
        end
        S_WB_WAIT: begin
          if (mem_rsp_valid) begin
            mem_lock      <= 1'b0;
            mem_req_write <= 1'b0;
            if (notify_q) begin
              ipi_valid <= 1'b1;
              st        <= S_NOTIFY;
            end else begin
              done  <= 1'b1;
              fault <= FLT_NONE;
              st    <= S_IDLE;
            end
          end
        end
        S_NOTIFY: begin
          if (ipi_ready) begin
            ipi_valid <= 1'b0;
            done      <= 1'b1;
            fault     <= FLT_NONE;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req_valid && !ipi_valid && !mem_lock)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_lock); // R5
  AST_IPI_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    ipi_valid |-> (!mem_lock && !mem_req_valid)); // R8
  AST_IPI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ipi_valid && !ipi_ready) |=> (ipi_valid && $stable(ipi_vector)
                                   && $stable(ipi_dest) && $stable(ipi_x2apic))); // R11
  AST_XAPIC_NARROW: assert property (@(posedge clk) disable iff (rst)
    (ipi_valid && !ipi_x2apic) |-> (ipi_dest[APIC_W-1:8] == '0)); // R9

endmodule

// File: tb/uipi_send_engine_test.sv
`timescale 1ns/1ps
module uipi_send_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         req_valid = 0, req_ready;
  logic [63:0]  req_index = '0;
  logic [63:0]  cfg_table_base = '0;
  logic [31:0]  cfg_table_size = '0;
  logic         cfg_x2apic = 0;
  logic         mem_req_valid, mem_req_write, mem_lock;
  logic         mem_req_ready = 1'b1;
  logic [63:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid = 0;
  logic [127:0] mem_rsp_data = '0;
  logic         ipi_valid, ipi_x2apic;
  logic         ipi_ready = 0;
  logic [7:0]   ipi_vector;
  logic [31:0]  ipi_dest;
  logic         done;
  logic [1:0]   fault;

  uipi_send_engine uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .cfg_table_base(cfg_table_base),
    .cfg_table_size(cfg_table_size), .cfg_x2apic(cfg_x2apic),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_lock(mem_lock),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ipi_valid(ipi_valid), .ipi_ready(ipi_ready), .ipi_vector(ipi_vector),
    .ipi_dest(ipi_dest), .ipi_x2apic(ipi_x2apic), .done(done), .fault(fault)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory and interrupt models
  localparam logic [63:0] TBL_AL = 64'h0000_0000_0010_2000;
  localparam logic [63:0] DPTR   = 64'h0000_0000_0004_0040;
  logic [127:0] tbl [0:7];
  logic [127:0] dsc_mem;
  logic         rsp_pend = 0;
  logic [127:0] rsp_dat;
  int           cyc = 0;
  int           n_rd, n_wr, n_ipi, n_done, ipi_cyc, done_cyc, ipi_wait, ipi_delay = 0;
  logic [63:0]  rd_addr [0:3];
  logic         rd_lock [0:3];
  logic [127:0] wr_data;
  logic         wr_lock, lock_at_done;
  logic [1:0]   last_fault;
  logic [7:0]   got_vec;
  logic [31:0]  got_dst;
  logic         got_mode;

  always @(negedge clk) begin
    cyc++;
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rsp_dat;
      rsp_pend      = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (!rst && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        n_wr++;
        wr_data = mem_req_wdata;
        wr_lock = mem_lock;
        if (mem_req_addr == DPTR) dsc_mem = mem_req_wdata;
        rsp_dat = '0;
      end else begin
        if (n_rd < 4) begin
          rd_addr[n_rd] = mem_req_addr;
          rd_lock[n_rd] = mem_lock;
        end
        n_rd++;
        if (mem_req_addr >= TBL_AL && mem_req_addr < TBL_AL + 64'd128)
          rsp_dat = tbl[(mem_req_addr - TBL_AL) >> 4];
        else if (mem_req_addr == DPTR) rsp_dat = dsc_mem;
        else rsp_dat = '0;
      end
      rsp_pend = 1'b1;
    end
    if (ipi_ready) ipi_ready = 1'b0;
    else if (ipi_valid) begin
      if (ipi_wait == 0) begin
        got_vec = ipi_vector; got_dst = ipi_dest; got_mode = ipi_x2apic;
      end else begin
        chk(ipi_vector == got_vec && ipi_dest == got_dst && ipi_x2apic == got_mode,
            "R11 ipi fields steady", {ipi_vector, ipi_dest}, {got_vec, got_dst});
      end
      if (ipi_wait >= ipi_delay) begin
        ipi_ready = 1'b1;
        n_ipi++;
        ipi_cyc = cyc;
      end
      ipi_wait++;
    end
    if (done) begin
      n_done++;
      done_cyc     = cyc;
      last_fault   = fault;
      lock_at_done = mem_lock;
    end
  end

  function automatic logic [127:0] mk_ent(input bit v, input logic [7:0] vec, input logic [63:0] p);
    return {p, 48'h0, vec, 7'h0, v};
  endfunction
  function automatic logic [127:0] mk_dsc(input bit on, input bit sn, input logic [7:0] nv,
                                          input logic [31:0] dst, input logic [63:0] pir);
    return {pir, dst, 8'h0, nv, 14'h0, sn, on};
  endfunction

  task automatic run_req(input logic [63:0] idx);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0; n_ipi = 0; n_done = 0; ipi_wait = 0; wr_data = '0;
    req_valid = 1'b1;
    req_index = idx;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 300 && n_done == 0; k++) @(negedge clk);
    chk(n_done == 1, "completion seen", 128'(n_done), 128'd1);
  endtask

  task automatic t_reset;
    chk(req_ready && !done && !mem_req_valid && !mem_lock && !ipi_valid,
        "R10 reset state", {req_ready, done, mem_req_valid, mem_lock, ipi_valid}, 128'h10);
  endtask

  task automatic t_disabled;
    cfg_table_base = TBL_AL;
    run_req(64'd0);
    chk(last_fault == 2'b10, "R1 fault code", 128'(last_fault), 128'd2);
    chk(n_rd == 0 && n_wr == 0, "R1 no memory access", 128'(n_rd + n_wr), 128'd0);
    cfg_table_base = TBL_AL | 64'h1;
  endtask

  task automatic t_range;
    run_req(64'd4);
    chk(last_fault == 2'b01 && n_rd == 0, "R2 index above size", {last_fault, 32'(n_rd)}, {2'b01, 32'd0});
    run_req(64'h1_0000_0000);
    chk(last_fault == 2'b01 && n_rd == 0, "R2 wide index", {last_fault, 32'(n_rd)}, {2'b01, 32'd0});
  endtask

  task automatic t_post(input bit on, input bit sn, input bit x2, input logic [7:0] vec,
                        input int idx, input int dly);
    logic [127:0] d, exp_w;
    bit note;
    d = mk_dsc(on, sn, 8'hA7, 32'h1234_5678, 64'h0000_0100_0000_0000);
    dsc_mem = d;
    tbl[idx] = mk_ent(1'b1, vec, DPTR);
    cfg_x2apic = x2;
    ipi_delay = dly;
    note = !on && !sn;
    exp_w = d | (128'd1 << (64 + vec)) | (note ? 128'd1 : 128'd0);
    run_req(64'(idx));
    chk(rd_addr[0] == TBL_AL + 64'(idx) * 16 && !rd_lock[0], "R3 slot read address unlocked",
        {rd_lock[0], rd_addr[0]}, TBL_AL + 64'(idx) * 16);
    chk(rd_addr[1] == DPTR && rd_lock[1], "R5 descriptor read locked", {rd_lock[1], rd_addr[1]}, {1'b1, DPTR});
    chk(n_wr == 1 && wr_lock, "R5 locked write-back", {wr_lock, 32'(n_wr)}, {1'b1, 32'd1});
    chk(wr_data == exp_w, "R7 write-back data", wr_data, exp_w);
    chk(last_fault == 2'b00 && !lock_at_done, "R10 success code", {lock_at_done, last_fault}, 128'd0);
    chk(n_ipi == (note ? 1 : 0), "R8 notification presence", 128'(n_ipi), 128'(note));
    if (note) begin
      chk(got_vec == 8'hA7, "R8 vector", 128'(got_vec), 128'hA7);
      chk(done_cyc == ipi_cyc + 1, "R8 done after accept", 128'(done_cyc), 128'(ipi_cyc + 1));
      chk(got_dst == (x2 ? 32'h1234_5678 : 32'h56) && got_mode == x2, "R9 destination",
          {got_mode, got_dst}, {x2, (x2 ? 32'h1234_5678 : 32'h56)});
    end
  endtask

  task automatic t_bad_slot(input logic [127:0] s, input string tag);
    tbl[1] = s;
    run_req(64'd1);
    chk(last_fault == 2'b01 && n_rd == 1 && n_wr == 0, tag, {last_fault, 32'(n_rd), 32'(n_wr)},
        {2'b01, 32'd1, 32'd0});
  endtask

  task automatic t_bad_desc(input int bitpos);
    dsc_mem = mk_dsc(0, 0, 8'h11, 32'h0, 64'h0) | (128'd1 << bitpos);
    tbl[2] = mk_ent(1'b1, 8'd3, DPTR);
    run_req(64'd2);
    chk(last_fault == 2'b01 && n_wr == 0 && n_ipi == 0 && !lock_at_done, "R6 descriptor reserved",
        {lock_at_done, last_fault, 32'(n_wr), 32'(n_ipi)}, {1'b0, 2'b01, 64'd0});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tbl[i] = '0;
    dsc_mem = '0;
    cfg_table_size = 32'd3;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_range();
    t_post(0, 0, 0, 8'd5, 3, 0);
    t_post(1, 0, 0, 8'd9, 0, 0);
    t_post(0, 1, 1, 8'd2, 2, 0);
    t_post(0, 0, 1, 8'd63, 1, 4);
    t_bad_slot(mk_ent(1'b0, 8'd1, DPTR), "R4 invalid slot");
    t_bad_slot(mk_ent(1'b1, 8'd64, DPTR), "R4 vector out of range");
    t_bad_slot(mk_ent(1'b1, 8'd1, DPTR | 64'h4), "R4 misaligned pointer");
    t_bad_slot(mk_ent(1'b1, 8'd1, DPTR) | (128'd1 << 40), "R4 reserved middle");
    t_bad_slot(mk_ent(1'b1, 8'd1, DPTR) | 128'h4, "R4 reserved low flags");
    t_bad_desc(5);
    t_bad_desc(28);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule